// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Bit Engine

This block is the bit-level layer of a two-wire serial bus master. A controller hands it one primitive at a time: a START condition, a STOP condition, a byte write, a byte read, or a bus-recovery sweep. The engine then sequences the clock and data lines and reports completion with a one-cycle done pulse. Byte writes return the acknowledge level that the addressed device put on the data line. Byte reads return the received byte, and the engine drives the acknowledge bit that the caller chose.

Both lines are open-drain. The engine never drives a high level: it asserts an output enable to pull a line low and releases the enable to let the pull-up take the line high. The data line is read back through a two-flop synchronizer. All bit timing is built from a quarter-period tick. The divider reload value `div_reload` is captured when a command is accepted, and each tick lasts `div_reload + 1` clock cycles.

Commands arrive on a valid/ready channel. `cmd_ready` is high only while the engine is idle, and a command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. A producer may hold `cmd_valid` high for as long as it likes. While the engine is busy, nothing is taken from the channel. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and the read data and acknowledge fields stay stable until the next byte command completes.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both enables are low (lines released), `busy` and `rsp_valid` are low and `cmd_ready` is high.
- R2: A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` equals the inverse of `busy`. A `cmd_valid` presented while busy does not change the line sequence, the completion time or the results, and it produces no extra done pulse.
- R3: A tick lasts `div_reload + 1` cycles, using the value captured at acceptance. `rsp_valid` pulses for one cycle exactly N ticks after the acceptance edge, where N is 3 for START, 4 for STOP, 36 for a byte write or read, 40 for recovery and 1 for an unused op code. A later change to `div_reload` does not alter a running command.
- R4: START first releases SDA, then releases SCL, then pulls SDA low while SCL is high, with one tick between steps. It finishes with SCL released and SDA pulled low.
- R5: STOP pulls SCL low, then pulls SDA low, then releases SCL, then releases SDA while SCL is high, with one tick per step. It finishes with both lines released.
- R6: A byte write sends `cmd_wdata` most significant bit first in nine four-tick slots. In each slot SCL is low for two ticks with SDA updated after the first tick, then SCL is released for two ticks. SDA changes only while SCL is low, and it is released for the ninth slot.
- R7: `rsp_nack` after a write is the SDA level sampled at the end of the ninth SCL high phase: 0 means the device acknowledged and 1 means it did not.
- R8: A byte read releases SDA for eight slots and shifts in the SDA level sampled at the end of each SCL high phase into `rsp_rdata`, most significant bit first. In the ninth slot the engine drives `cmd_ack`, where 0 pulls SDA low to acknowledge and 1 releases it. `rsp_nack` then returns the level seen in that slot.
- R9: Recovery releases SDA, gives nine SCL low/high pulses of two ticks per half, and then runs the STOP sequence. The lines see ten SCL rising edges and one STOP condition, and both lines end released.
- R10: Op codes are 0 START, 1 STOP, 2 WRITE, 3 READ and 4 RECOVER. Codes 5 to 7 complete after one tick without moving either line.
- R11: `rsp_rdata` and `rsp_nack` change only when a WRITE or READ completes, and they hold their values through any other command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_reload | input | 16 | Quarter-period tick reload; a tick lasts div_reload+1 cycles |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 3 | Operation code (see R10) |
| cmd_wdata | input | 8 | Byte to send for WRITE |
| cmd_ack | input | 1 | Acknowledge bit to drive after a READ byte (0 = ACK) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte received by the last READ |
| rsp_nack | output | 1 | Ninth-slot SDA level of the last WRITE or READ |
| busy | output | 1 | Command in progress |
| sda_i | input | 1 | SDA line level from the pad |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
Every result is due a fixed number of cycles after the acceptance edge: ticks × (div_reload + 1), with 3, 4, 36, 40 or 1 ticks depending on the command. The driver records the edge count at acceptance and pushes the exact completion edge together with the expected byte and acknowledge. The monitor pops that item on the sampling point where `rsp_valid` is seen and compares the edge count as well as the data. Line states, bus events counted by a passive observer and the captured bytes of a behavioural slave are sampled between edges, only after the done pulse.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  // Command op codes (decoded by the sequencer)
  localparam logic [2:0] OP_START   = 3'd0;
  localparam logic [2:0] OP_STOP    = 3'd1;
  localparam logic [2:0] OP_WRITE   = 3'd2;
  localparam logic [2:0] OP_READ    = 3'd3;
  localparam logic [2:0] OP_RECOVER = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_STOP,
    ST_SLOT,
    ST_NOP
  } seq_st_e;

  typedef enum logic [1:0] {
    SK_WRITE,
    SK_READ,
    SK_RECOVER
  } slot_kind_e;

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);

  logic [DIV_W-1:0] rl_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_q  <= '0;
      cnt_q <= '0;
    end else if (start) begin
      rl_q  <= reload;
      cnt_q <= reload;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= rl_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = run && !start && (cnt_q == '0);

  // R3: with a reload above zero, ticks never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rl_q != '0) |=> !tick);

endmodule

// File: rtl/i2c_sync2.sv
module i2c_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // lines idle high, so the stages reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
  import i2c_eng_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int RECOV_PULSES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_ack,
  input  logic              tick,
  input  logic              sda_s,
  output logic              busy,
  output logic              scl_rel,
  output logic              sda_rel,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_nack
);

  localparam int SLOTS     = DATA_W + 1;
  localparam int MAX_SLOTS = (SLOTS > RECOV_PULSES) ? SLOTS : RECOV_PULSES;
  localparam int CNT_W     = $clog2(MAX_SLOTS);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] LAST_REC  = CNT_W'(RECOV_PULSES - 1);

  seq_st_e           st;
  slot_kind_e        kind;
  logic [1:0]        q;
  logic [CNT_W-1:0]  slot;
  logic [DATA_W-1:0] tx;
  logic [DATA_W-1:0] rx;
  logic              ack_q;

  logic              bit_val;
  logic [SLOTS-1:0]  rx_nxt;
  logic [CNT_W-1:0]  last_slot;
  logic              data_slot;

  assign data_slot = int'(slot) < DATA_W;
  assign rx_nxt    = {rx, sda_s};
  assign last_slot = (kind == SK_RECOVER) ? LAST_REC : LAST_BYTE;

  // level the master puts on SDA during the current slot (1 = released)
  always_comb begin
    case (kind)
      SK_WRITE: bit_val = data_slot ? tx[DATA_W-1] : 1'b1;
      SK_READ:  bit_val = data_slot ? 1'b1 : ack_q;
      default:  bit_val = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= SK_WRITE;
      q         <= '0;
      slot      <= '0;
      tx        <= '0;
      rx        <= '0;
      ack_q     <= 1'b1;
      busy      <= 1'b0;
      scl_rel   <= 1'b1;
      sda_rel   <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_nack  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_fire) begin
            busy <= 1'b1;
            q    <= '0;
            slot <= '0;
            case (cmd_op)
              OP_START: begin
                sda_rel <= 1'b1;
                st      <= ST_START;
              end
              OP_STOP: begin
                scl_rel <= 1'b0;
                st      <= ST_STOP;
              end
              OP_WRITE: begin
                scl_rel <= 1'b0;
                tx      <= cmd_wdata;
                kind    <= SK_WRITE;
                st      <= ST_SLOT;
              end
              OP_READ: begin
                scl_rel <= 1'b0;
                ack_q   <= cmd_ack;
                kind    <= SK_READ;
                st      <= ST_SLOT;
              end
              OP_RECOVER: begin
                scl_rel <= 1'b0;
                sda_rel <= 1'b1;
                kind    <= SK_RECOVER;
                st      <= ST_SLOT;
              end
              default: st <= ST_NOP;
            endcase
          end
        end

        ST_START: begin
          if (tick) begin
            q <= q + 1'b1;
            case (q)
              2'd0: scl_rel <= 1'b1;
              2'd1: sda_rel <= 1'b0;
              default: begin
                st        <= ST_IDLE;
                busy      <= 1'b0;
                rsp_valid <= 1'b1;
              end
            endcase
          end
        end

        ST_STOP: begin
          if (tick) begin
            q <= q + 1'b1;
            case (q)
              2'd0: sda_rel <= 1'b0;
              2'd1: scl_rel <= 1'b1;
              2'd2: sda_rel <= 1'b1;
              default: begin
                st        <= ST_IDLE;
                busy      <= 1'b0;
                rsp_valid <= 1'b1;
              end
            endcase
          end
        end

        ST_SLOT: begin
          if (tick) begin
            q <= q + 1'b1;
            case (q)
              2'd0: sda_rel <= bit_val;
              2'd1: scl_rel <= 1'b1;
              2'd2: ;
              default: begin
                rx      <= rx_nxt[DATA_W-1:0];
                scl_rel <= 1'b0;
                if (kind == SK_WRITE) tx <= tx << 1;
                if (slot == last_slot) begin
                  if (kind == SK_RECOVER) begin
                    st <= ST_STOP;
                  end else begin
                    st        <= ST_IDLE;
                    busy      <= 1'b0;
                    rsp_valid <= 1'b1;
                    rsp_rdata <= rx_nxt[SLOTS-1:1];
                    rsp_nack  <= rx_nxt[0];
                  end
                end else begin
                  slot <= slot + 1'b1;
                end
              end
            endcase
          end
        end

        ST_NOP: begin
          if (tick) begin
            st        <= ST_IDLE;
            busy      <= 1'b0;
            rsp_valid <= 1'b1;
          end
        end

        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: inside a bit slot SDA holds still while SCL stays released
  p_sda_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOT && $past(st) == ST_SLOT && scl_rel && $past(scl_rel))
      |-> $stable(sda_rel));

  // R7: sampling happens only while SCL is released
  p_sample_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOT && tick && q == 2'd3) |-> scl_rel);

  // R4: SDA is pulled low while SCL is already released
  p_start_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && tick && q == 2'd1) |-> scl_rel);

  // R5: the last STOP step leaves both lines released and reports done
  p_stop_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && tick && q == 2'd3) |=> (scl_rel && sda_rel && rsp_valid));

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int DIV_W        = 16,
  parameter int DATA_W       = 8,
  parameter int RECOV_PULSES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_reload,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_ack,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_nack,
  output logic              busy,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);

  logic fire;
  logic tick;
  logic sda_s;
  logic scl_rel;
  logic sda_rel;

  assign cmd_ready = !busy;
  assign fire      = cmd_valid && cmd_ready;

  i2c_qtick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (fire),
    .run    (busy),
    .reload (div_reload),
    .tick   (tick)
  );

  i2c_sync2 #(.W(1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sda_i),
    .q     (sda_s)
  );

  i2c_bit_seq #(.DATA_W(DATA_W), .RECOV_PULSES(RECOV_PULSES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_fire  (fire),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .cmd_ack   (cmd_ack),
    .tick      (tick),
    .sda_s     (sda_s),
    .busy      (busy),
    .scl_rel   (scl_rel),
    .sda_rel   (sda_rel),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_nack  (rsp_nack)
  );

  assign scl_oe = !scl_rel;
  assign sda_oe = !sda_rel;

  // R2: an accepted command makes the engine busy on the next cycle
  p_fire_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  // R3: a done pulse only ever closes a busy period
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(busy));

  // R3: done lasts one cycle
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/tb_i2c_bit_engine.sv
module tb_i2c_bit_engine;

  localparam logic [6:0] SLV_ADDR = 7'h50;
  localparam logic [7:0] SLV_RD   = 8'hC5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_reload = 16'd3;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [7:0]  cmd_wdata = 8'h00;
  logic        cmd_ack = 1'b1;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        rsp_nack;
  logic        busy;
  logic        scl_oe;
  logic        sda_oe;
  logic        s_pull = 1'b0;

  wire scl_bus = ~scl_oe;
  wire sda_bus = ~(sda_oe | s_pull);

  always #4 clk = ~clk;  // 125 MHz

  i2c_bit_engine dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_reload (div_reload),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_wdata  (cmd_wdata),
    .cmd_ack    (cmd_ack),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_nack   (rsp_nack),
    .busy       (busy),
    .sda_i      (sda_bus),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int divv = 3;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    int         exp_cyc;
    bit         chk_data;
    logic [7:0] data;
    bit         chk_nack;
    logic       nack;
    string      req;
  } exp_t;

  exp_t sb[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.exp_cyc, e.req, "done cycle", cyc, e.exp_cyc);
        if (e.chk_data) check(rsp_rdata == e.data, e.req, "rdata", rsp_rdata, e.data);
        if (e.chk_nack) check(rsp_nack == e.nack, e.req, "nack", rsp_nack, e.nack);
      end
    end
  end

  // ---------------- bus observer and slave model ----------------
  logic scl_p = 1'b1, sda_p = 1'b1;
  int   rise_cnt = 0, start_cnt = 0, stop_cnt = 0, viol = 0;
  bit   slot_op = 1'b0;
  bit   s_act = 1'b0, s_match = 1'b0, s_mack = 1'b0;
  int   s_phase = 0, s_cnt = 0;
  logic [7:0] s_sh = 8'h00, s_last = 8'h00;

  always @(scl_bus or sda_bus) begin
    if (scl_bus && scl_p && sda_p && !sda_bus) begin
      start_cnt++;
      if (slot_op) viol++;
      s_act = 1'b1; s_phase = 0; s_cnt = 0; s_pull = 1'b0;
    end else if (scl_bus && scl_p && !sda_p && sda_bus) begin
      stop_cnt++;
      if (slot_op) viol++;
      s_act = 1'b0; s_pull = 1'b0;
    end
    if (scl_bus && !scl_p) begin
      rise_cnt++;
      if (s_act) begin
        if (s_cnt < 8) begin
          if (s_phase != 2) s_sh = {s_sh[6:0], sda_bus};
        end else if (s_cnt == 8 && s_phase == 2) begin
          s_mack = sda_bus;
        end
        s_cnt++;
      end
    end
    if (!scl_bus && scl_p && s_act) begin
      if (s_phase == 2) begin
        if (s_cnt >= 1 && s_cnt <= 7) s_pull = ~SLV_RD[7-s_cnt];
        else if (s_cnt == 8) s_pull = 1'b0;
        else if (s_cnt == 9) begin
          s_cnt = 0;
          if (s_mack) s_act = 1'b0;
          else s_pull = ~SLV_RD[7];
        end
      end else begin
        if (s_cnt == 8) begin
          s_last = s_sh;
          if (s_phase == 0) begin
            s_match = (s_sh[7:1] == SLV_ADDR);
            s_pull  = s_match;
          end else begin
            s_pull = 1'b1;
          end
        end else if (s_cnt == 9) begin
          s_pull = 1'b0;
          s_cnt  = 0;
          if (s_phase == 0) begin
            if (!s_match) s_act = 1'b0;
            else if (s_sh[0]) begin
              s_phase = 2;
              s_pull  = ~SLV_RD[7];
            end else s_phase = 1;
          end
        end
      end
    end
    scl_p = scl_bus;
    sda_p = sda_bus;
  end

  // ---------------- driver ----------------
  task automatic wait_done();
    do @(negedge clk); while (!rsp_valid);
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] wd, input logic ack,
                       input int ticks, input bit cd, input logic [7:0] ed,
                       input bit cn, input logic en, input string req,
                       input int alt_div);
    exp_t e;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    div_reload = 16'(divv);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_ack = ack;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    e.exp_cyc = cyc + ticks * (divv + 1);
    e.chk_data = cd; e.data = ed; e.chk_nack = cn; e.nack = en; e.req = req;
    sb.push_back(e);
    if (alt_div >= 0) div_reload = 16'(alt_div);
    wait_done();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run timed out", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int r0, k0, t0;
    repeat (5) @(negedge clk);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "lines released", {scl_oe, sda_oe}, 0);
    check(cmd_ready == 1'b1, "R1", "ready in reset", cmd_ready, 1);
    check(rsp_valid == 1'b0 && busy == 1'b0, "R1", "idle in reset", {rsp_valid, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(scl_oe == 1'b0 && sda_oe == 1'b0 && cmd_ready, "R1", "idle after reset",
          {scl_oe, sda_oe, cmd_ready}, 1);

    // R9: recovery sweep
    r0 = rise_cnt; k0 = stop_cnt;
    issue(3'd4, 8'h00, 1'b1, 40, 0, 8'h00, 0, 1'b0, "R9", -1);
    check(rise_cnt - r0 == 10, "R9", "SCL rising edges", rise_cnt - r0, 10);
    check(stop_cnt - k0 == 1, "R9", "STOP count", stop_cnt - k0, 1);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R9", "lines released", {scl_oe, sda_oe}, 0);

    // R4: START
    t0 = start_cnt;
    issue(3'd0, 8'h00, 1'b1, 3, 0, 8'h00, 0, 1'b0, "R4", -1);
    check(start_cnt - t0 == 1, "R4", "START condition seen", start_cnt - t0, 1);
    check(scl_oe == 1'b0 && sda_oe == 1'b1, "R4", "end state", {scl_oe, sda_oe}, 1);

    // R6 R7: address write acked, then data write
    slot_op = 1'b1;
    issue(3'd2, 8'hA0, 1'b1, 36, 0, 8'h00, 1, 1'b0, "R7", -1);
    check(s_last == 8'hA0, "R6", "slave captured address", s_last, 8'hA0);
    issue(3'd2, 8'h3C, 1'b1, 36, 0, 8'h00, 1, 1'b0, "R7", -1);
    check(s_last == 8'h3C, "R6", "slave captured data", s_last, 8'h3C);
    slot_op = 1'b0;

    // R8: repeated START, read address, two reads
    issue(3'd0, 8'h00, 1'b1, 3, 0, 8'h00, 0, 1'b0, "R4", -1);
    slot_op = 1'b1;
    issue(3'd2, 8'hA1, 1'b1, 36, 0, 8'h00, 1, 1'b0, "R7", -1);
    issue(3'd3, 8'h00, 1'b0, 36, 1, SLV_RD, 1, 1'b0, "R8", -1);
    issue(3'd3, 8'h00, 1'b1, 36, 1, SLV_RD, 1, 1'b1, "R8", -1);
    slot_op = 1'b0;
    check(viol == 0, "R6", "SDA moved while SCL high in a slot", viol, 0);

    // R5: STOP
    k0 = stop_cnt;
    issue(3'd1, 8'h00, 1'b1, 4, 0, 8'h00, 0, 1'b0, "R5", -1);
    check(stop_cnt - k0 == 1, "R5", "STOP condition seen", stop_cnt - k0, 1);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R5", "lines released", {scl_oe, sda_oe}, 0);

    // R11: results hold
    repeat (10) @(negedge clk);
    check(rsp_rdata == SLV_RD && rsp_nack == 1'b1, "R11", "held result",
          {rsp_rdata, rsp_nack}, {SLV_RD, 1'b1});

    // R10: unused op code
    issue(3'd6, 8'h00, 1'b1, 1, 0, 8'h00, 0, 1'b0, "R10", -1);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R10", "lines untouched", {scl_oe, sda_oe}, 0);
    check(rsp_rdata == SLV_RD && rsp_nack == 1'b1, "R11", "held after unused op",
          {rsp_rdata, rsp_nack}, {SLV_RD, 1'b1});

    // R7: unmatched address is not acknowledged
    issue(3'd0, 8'h00, 1'b1, 3, 0, 8'h00, 0, 1'b0, "R4", -1);
    issue(3'd2, 8'h44, 1'b1, 36, 0, 8'h00, 1, 1'b1, "R7", -1);
    issue(3'd1, 8'h00, 1'b1, 4, 0, 8'h00, 0, 1'b0, "R5", -1);

    // R2: command presented while busy is not taken
    begin
      exp_t e;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd0;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
      e.exp_cyc = cyc + 3 * (divv + 1);
      e.chk_data = 0; e.data = 8'h00; e.chk_nack = 0; e.nack = 1'b0; e.req = "R2";
      sb.push_back(e);
      repeat (3) @(negedge clk);
      check(cmd_ready == 1'b0, "R2", "ready while busy", cmd_ready, 0);
      cmd_valid = 1'b1; cmd_op = 3'd1;
      repeat (2) @(negedge clk);
      cmd_valid = 1'b0;
      wait_done();
      check(scl_oe == 1'b0 && sda_oe == 1'b1, "R2", "START end state kept",
            {scl_oe, sda_oe}, 1);
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R2", "no second command", busy, 0);
    end

    // R3: slower divider, captured at acceptance
    divv = 7;
    issue(3'd1, 8'h00, 1'b1, 4, 0, 8'h00, 0, 1'b0, "R3", 1);
    divv = 3;
    issue(3'd6, 8'h00, 1'b1, 1, 0, 8'h00, 0, 1'b0, "R3", -1);

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R3", "missing done pulses", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule